// File: doc/BRIEF.md
# Delay-Range Sequence Match Monitor

The monitor watches two single-bit inputs, `a` and `b`, and raises `match` in any cycle where `b` is true and an occurrence of `a` lies between `DLY_MIN` and `DLY_MAX` cycles earlier. When `UNBOUNDED` is set, the upper limit is dropped and any delay of at least `DLY_MIN` counts. The block is a nondeterministic automaton with one flip-flop per state. Because each state is a flag of its own, any number of overlapping attempts share the hardware. A new attempt can open in every cycle.

The states come in three kinds. The **entry** state is reached from the start state when `a` is seen. **Fixed** states, numbered 1 to `DLY_MIN`, each add one cycle of mandatory delay. **Window** states, numbered `DLY_MIN+1` to `DLY_MAX`, cover the optional extra cycles. There are three kinds of transition. An **edge** moves activity to the next state at the clock. A **link** makes the target active in the same cycle. A **self-edge** on the last fixed state keeps an attempt waiting indefinitely in the unbounded variant. Each window state is reached by both an edge and a link from its predecessor, so an attempt can leave the window early. The exit path links the last state, gated by `b`, to the accept state, and `match` is that accept state's value in the same cycle.

Three inputs shape tracking. `arm` is the start trigger; tie it high for a free-running monitor. `hold` is a qualifier that gates every edge and link. `dis` is a synchronous kill for all tracking.

Top module: `seq_delay_monitor`

## Requirements
- R1: After `rst_n` (active low, asynchronous) is released, and with no `a` applied, `match` is 0.
- R2: `match` is a combinational output. It is 1 in the cycle where `b`=1 when an attempt opened `d` cycles earlier, with `DLY_MIN` ≤ d ≤ `DLY_MAX`. It is never 1 while `b`=0.
- R3: With a bounded window, an attempt gives no `match` when `b` comes earlier than `DLY_MIN` cycles or later than `DLY_MAX` cycles after `a`. This includes `b` in the same cycle as `a` when `DLY_MIN` > 0.
- R4: With `UNBOUNDED`=1, an attempt waits indefinitely. A `b` at any delay of at least `DLY_MIN` gives `match`.
- R5: Overlapping attempts are tracked independently. Every live attempt whose age is inside the window yields `match` on `b`, whatever the attempts before or after it are doing.
- R6: In a cycle with `dis`=1, `match` is 0. Every attempt live in that cycle or opened in it is discarded, so the following cycle starts with all states at 0.
- R7: `hold` must be 1 in every cycle from the `a` cycle through the `b` cycle inclusive. A cycle with `hold`=0 kills every live attempt, and `match` is 0 in that cycle.
- R8: When `arm`=0, an `a` in that cycle opens no attempt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears all states |
| arm | input | 1 | Start trigger; an attempt may open only when 1 |
| hold | input | 1 | Qualifier gating every transition (active high) |
| dis | input | 1 | Synchronous disable of all tracking (active high) |
| a | input | 1 | Opening condition of the sequence |
| b | input | 1 | Closing condition of the sequence |
| match | output | 1 | Sequence completed this cycle |

## Verification
The assertions hold on every cycle for the relations that need no history: `match` stays low whenever `b`, `hold` or the inverse of `dis` is low. After a `dis` cycle, all state flags are clear. From an all-clear state without an armed `a`, the flags remain clear. Whether a match falls at the right delay depends on past inputs, so only the bench scenarios can show it. The bench compares against an age-tracking reference model. The scenarios cover window edges, waits far beyond the lower bound, interleaved attempts, and disable or qualifier drops in the middle of an attempt. A bounded and an unbounded instance run side by side on the same inputs.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    typedef enum logic [1:0] {
        NK_ENTRY  = 2'd0,
        NK_FIXED  = 2'd1,
        NK_WINDOW = 2'd2
    } node_kind_e;

    // number of state flags in the delay chain (entry node included)
    function automatic int node_count(input int dly_min, input int dly_max, input bit unb);
        return unb ? (dly_min + 1) : (dly_max + 1);
    endfunction

    function automatic node_kind_e kind_of(input int idx, input int dly_min);
        if (idx == 0)
            return NK_ENTRY;
        else if (idx <= dly_min)
            return NK_FIXED;
        else
            return NK_WINDOW;
    endfunction

    function automatic bit has_self_loop(input int idx, input int dly_min, input bit unb);
        return unb && (idx == dly_min);
    endfunction

endpackage

// File: rtl/sdm_start.sv
// Start state: always active when the trigger is high, then linked to the
// entry node through condition a.
module sdm_start (
    input  logic arm,
    input  logic dis,
    input  logic a,
    output logic start_term
);
    logic start_eff;

    always_comb begin
        start_eff  = arm & ~dis;
        start_term = start_eff & a;
    end
endmodule

// File: rtl/sdm_node.sv
// One automaton state: a flag register plus its effective value.
module sdm_node #(
    parameter bit SELF_LOOP = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dis,
    input  logic hold,
    input  logic edge_src,
    input  logic link_src,
    output logic eff,
    output logic q
);
    logic q_r;
    logic nxt;
    logic self_term;

    generate
        if (SELF_LOOP) begin : g_self
            always_comb self_term = eff & hold;
        end else begin : g_noself
            always_comb self_term = 1'b0;
        end
    endgenerate

    always_comb begin
        eff = (q_r | (link_src & hold)) & ~dis;
        nxt = (edge_src & hold) | self_term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_r <= 1'b0;
        else
            q_r <= nxt;
    end

    assign q = q_r;
endmodule

// File: rtl/sdm_chain.sv
// Delay chain: entry node, DLY_MIN fixed nodes, then window nodes.
module sdm_chain
    import sdm_pkg::*;
#(
    parameter int DLY_MIN   = 1,
    parameter int DLY_MAX   = 3,
    parameter bit UNBOUNDED = 1'b0,
    localparam int NODES    = node_count(DLY_MIN, DLY_MAX, UNBOUNDED)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dis,
    input  logic             hold,
    input  logic             start_term,
    output logic             tail_eff,
    output logic [NODES-1:0] state_q
);
    logic [NODES-1:0] eff;

    generate
        for (genvar i = 0; i < NODES; i++) begin : g_node
            localparam node_kind_e KIND = kind_of(i, DLY_MIN);
            localparam bit         LOOP = has_self_loop(i, DLY_MIN, UNBOUNDED);
            if (KIND == NK_ENTRY) begin : g_entry
                sdm_node #(.SELF_LOOP(LOOP)) u_node (
                    .clk(clk), .rst_n(rst_n), .dis(dis), .hold(hold),
                    .edge_src(1'b0), .link_src(start_term),
                    .eff(eff[i]), .q(state_q[i])
                );
            end else if (KIND == NK_FIXED) begin : g_fixed
                sdm_node #(.SELF_LOOP(LOOP)) u_node (
                    .clk(clk), .rst_n(rst_n), .dis(dis), .hold(hold),
                    .edge_src(eff[i-1]), .link_src(1'b0),
                    .eff(eff[i]), .q(state_q[i])
                );
            end else begin : g_window
                // edge and link from the predecessor: optional extra cycle
                sdm_node #(.SELF_LOOP(LOOP)) u_node (
                    .clk(clk), .rst_n(rst_n), .dis(dis), .hold(hold),
                    .edge_src(eff[i-1]), .link_src(eff[i-1]),
                    .eff(eff[i]), .q(state_q[i])
                );
            end
        end
    endgenerate

    assign tail_eff = eff[NODES-1];
endmodule

// File: rtl/sdm_exit.sv
// Exit path: link through condition b, then link into the accept state.
module sdm_exit (
    input  logic tail_eff,
    input  logic b,
    input  logic hold,
    output logic accept
);
    logic close_eff;

    always_comb begin
        close_eff = tail_eff & b & hold;
        accept    = close_eff & hold;
    end
endmodule

// File: rtl/seq_delay_monitor.sv
module seq_delay_monitor
    import sdm_pkg::*;
#(
    parameter int DLY_MIN   = 1,
    parameter int DLY_MAX   = 3,
    parameter bit UNBOUNDED = 1'b0,
    localparam int NODES    = node_count(DLY_MIN, DLY_MAX, UNBOUNDED)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic hold,
    input  logic dis,
    input  logic a,
    input  logic b,
    output logic match
);
    logic             start_term;
    logic             tail_eff;
    logic [NODES-1:0] state_q;

    sdm_start u_start (
        .arm(arm), .dis(dis), .a(a), .start_term(start_term)
    );

    sdm_chain #(
        .DLY_MIN(DLY_MIN), .DLY_MAX(DLY_MAX), .UNBOUNDED(UNBOUNDED)
    ) u_chain (
        .clk(clk), .rst_n(rst_n), .dis(dis), .hold(hold),
        .start_term(start_term), .tail_eff(tail_eff), .state_q(state_q)
    );

    sdm_exit u_exit (
        .tail_eff(tail_eff), .b(b), .hold(hold), .accept(match)
    );
endmodule

// File: rtl/sdm_checker.sv
module sdm_checker #(
    parameter int NODES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             hold,
    input logic             dis,
    input logic             a,
    input logic             b,
    input logic             match,
    input logic [NODES-1:0] state_q
);
    p_dis_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dis |-> !match);

    p_dis_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> (state_q == '0));

    p_need_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !b |-> !match);

    p_hold_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> !match);

    p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == '0) && !(arm && a)) |=> (state_q == '0));
endmodule

bind seq_delay_monitor sdm_checker #(.NODES(NODES)) u_chk (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hold(hold), .dis(dis),
    .a(a), .b(b), .match(match), .state_q(state_q)
);

// File: tb/seq_delay_monitor_tb.sv
`timescale 1ns/1ps
module seq_delay_monitor_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b1, hold = 1'b1, dis = 1'b0, a = 1'b0, b = 1'b0;
    logic m_bnd, m_unb;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic  exp_bnd;
        logic  exp_unb;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    // reference model: bit k set = a live attempt of age k
    bit [7:0] age_bnd = '0;   // window 1..3
    bit [7:0] age_unb = '0;   // window 2..inf, age saturates at 2

    always #10 clk = ~clk;    // 50 MHz

    seq_delay_monitor #(.DLY_MIN(1), .DLY_MAX(3), .UNBOUNDED(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .hold(hold), .dis(dis),
        .a(a), .b(b), .match(m_bnd)
    );

    seq_delay_monitor #(.DLY_MIN(2), .DLY_MAX(2), .UNBOUNDED(1'b1)) u_dut_unb (
        .clk(clk), .rst_n(rst_n), .arm(arm), .hold(hold), .dis(dis),
        .a(a), .b(b), .match(m_unb)
    );

    task automatic step(input logic ia, input logic ib, input logic iarm,
                        input logic ihold, input logic idis, input string tag);
        bit [7:0] cb, cu, nu;
        exp_t e;
        @(negedge clk);
        #1;
        a = ia; b = ib; arm = iarm; hold = ihold; dis = idis;
        cb = age_bnd; cu = age_unb;
        cb[0] = iarm & ia;
        cu[0] = iarm & ia;
        if (idis || !ihold) begin
            cb = '0;
            cu = '0;
        end
        e.exp_bnd = ib && (|cb[3:1]);
        e.exp_unb = ib && (|cu[7:2]);
        e.tag = tag;
        sb_q.push_back(e);
        age_bnd = {cb[6:0], 1'b0} & 8'h0F;
        nu = {cu[6:0], 1'b0};
        nu[2] = nu[2] | cu[2];
        age_unb = nu & 8'h07;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, tag);
    endtask

    task automatic flush();
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
    endtask

    // monitor: pops one expected item per cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (m_bnd !== e.exp_bnd) begin
                    errors++;
                    $display("FAIL %s: bounded match=%0b expected %0b", e.tag, m_bnd, e.exp_bnd);
                end
                checks++;
                if (m_unb !== e.exp_unb) begin
                    errors++;
                    $display("FAIL %s: unbounded match=%0b expected %0b", e.tag, m_unb, e.exp_unb);
                end
            end
        end
    end

    task automatic run_all();
        bit [15:0] lfsr;
        // R1: reset state
        #1;
        checks++;
        if (m_bnd !== 1'b0 || m_unb !== 1'b0) begin
            errors++;
            $display("FAIL R1: match during reset %0b/%0b expected 0/0", m_bnd, m_unb);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(3, "R1");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R1");

        // R2/R3/R4: single attempt, b at delays 0..5
        for (int d = 0; d <= 5; d++) begin
            flush();
            step(1'b1, (d == 0), 1'b1, 1'b1, 1'b0, "R3");
            for (int k = 1; k <= d; k++)
                step(1'b0, (k == d), 1'b1, 1'b1, 1'b0, (d >= 1 && d <= 3) ? "R2" : "R3");
            idle(2, "R4");
        end

        // R4: long wait for the unbounded instance
        flush();
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
        idle(12, "R4");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R4");

        // R5: overlapping attempts
        flush();
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R5");

        // R6: disable mid-attempt, including with b high
        flush();
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R6");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");

        // R7: qualifier drop mid-attempt and in the b cycle
        flush();
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
        flush();
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");

        // R8: a without trigger
        flush();
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R8");

        // R5: pseudo-random stream against the model
        flush();
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[3], (lfsr[7:5] != 3'd0), (lfsr[11:9] != 3'd0),
                 (lfsr[15:12] == 4'd0), "R5");
        end
        idle(2, "R5");
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                #4_000_000;
                checks++;
                errors++;
                $display("FAIL watchdog: run did not finish, got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule